// File: doc/BRIEF.md
# Page-Walk Fault Priority Resolver

This block follows one page-table walk, step by step, and settles the single fault type that the walk's response carries. The walk may run through a first translation stage, a second (guest-physical) stage, both, or neither. The walker feeds the block one event per step. Each event holds the step's stage, whether it is the last (4 KiB) level, whether the protection check before the memory read failed, the returned PTE's valid, read, write and execute bits, and a group of PTEs fetched together with a flag per entry for non-zero high PPN bits. When the walker signals the end of the walk, the block reports one code: no fault, page fault, guest page fault, or access fault.

The fault types are ranked. A failed protection check before a read outranks everything. Next come page faults and guest page faults, where the first one seen wins. An access fault caused by non-zero high PPN bits comes last and is held back until the walk ends. The block also raises a halt flag as soon as a fault that cannot be overtaken has been recorded, so the walker can stop early. It gives a per-step decision on whether the fetched PTE group may be written into the PTE cache.

Top module: `walk_fault_resolver`

## Requirements
- R1: `mode_i` selects the active stages: 2'b00 both stages, 2'b01 first stage only, 2'b10 second stage only, 2'b11 no second-stage translation (only the first stage is active). A step flagged with a stage that is not active contributes no fault.
- R2: Fault codes are 2'b00 none, 2'b01 page fault, 2'b10 guest page fault, 2'b11 access fault. `done_o` is high for exactly the one cycle after the clock edge that samples `walk_end_i`. `fault_code_o` holds the resolved code in that cycle. `fault_valid_o` is high in that same cycle exactly when the code is non-zero. Out of reset all outputs are 0.
- R3: A step with `chk_fail_i` high in an active stage yields an access fault, whatever that step's PTE bits are.
- R4: A PTE with v=0, with w=1 and r=0, or at the last level with r=w=x=0 is bad. A bad PTE gives a page fault on a first-stage step and a guest page fault on a second-stage step. A valid non-leaf PTE below the last level is no fault.
- R5: The first access, page or guest page fault recorded in a walk is kept. Faults in later steps do not replace it. `halt_o` is high from the cycle after it is recorded until the state is cleared.
- R6: In first-stage-only mode and in no-second-stage mode a guest page fault is never reported. In second-stage-only mode a page fault is never reported.
- R7: A high-PPN access fault, taken from the entry of `grp_hi_nz_i` that `grp_sel_i` points at in an active, non-failing step, is latched. It is reported only if no other fault was recorded by the end of the walk.
- R8: `refill_ok_o` is high only during a step with `step_valid_i` high and `chk_fail_i` low. In second-stage-only mode, only the entry selected by `grp_sel_i` can block the refill. In the other modes, any set bit of `grp_hi_nz_i` blocks it.
- R9: `start_i` or `flush_i` clears the recorded and latched faults. A step given in the same cycle as `start_i` counts toward the new walk. A flush in the same cycle as `walk_end_i` suppresses `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | New walk request; clears fault state |
| flush_i | input | 1 | Flush; clears fault state and suppresses completion |
| mode_i | input | 2 | Translation mode (R1 encoding) |
| step_valid_i | input | 1 | A walk step event is present |
| step_stage2_i | input | 1 | Step belongs to the second stage |
| step_last_i | input | 1 | Step is at the last (4 KiB) level |
| chk_fail_i | input | 1 | Protection check before the read failed |
| pte_v_i | input | 1 | PTE valid bit |
| pte_r_i | input | 1 | PTE read bit |
| pte_w_i | input | 1 | PTE write bit |
| pte_x_i | input | 1 | PTE execute bit |
| grp_hi_nz_i | input | GROUP | Per-entry non-zero high PPN flags of the fetched group |
| grp_sel_i | input | SEL_W | Index of the walked PTE within the group |
| walk_end_i | input | 1 | Walker ends the walk in this cycle |
| done_o | output | 1 | Walk result is valid |
| fault_valid_o | output | 1 | A fault is reported with the result |
| fault_code_o | output | 2 | Resolved fault code |
| halt_o | output | 1 | A fault that cannot be overtaken is recorded |
| refill_ok_o | output | 1 | The fetched group may be refilled into the cache |

## Verification
Embedded assertions check several rules on every cycle. The per-step classifier never produces a guest fault or page fault that the current mode forbids. A pre-read check failure in an active stage always classifies as an access fault. A recorded fault stays fixed until cleared. Completion only follows a sampled walk end without a flush, and refill is never allowed when any group flag is set outside second-stage-only mode. Some behaviour only the bench's directed walks can show. That covers the ranking across steps: first fault wins, a deferred high-PPN fault gives way to a later page fault, and it surfaces when nothing else happens. It also covers the exact code reported at the walk end and the clearing by start and flush.

// File: rtl/wfr_pkg.sv
package wfr_pkg;
   typedef enum logic [1:0] {
      MODE_BOTH = 2'b00,
      MODE_S1   = 2'b01,
      MODE_S2   = 2'b10,
      MODE_BARE = 2'b11
   } xlate_mode_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'b00,
      FLT_PF   = 2'b01,
      FLT_GPF  = 2'b10,
      FLT_AF   = 2'b11
   } fault_e;

   function automatic logic stage_active(input xlate_mode_e m, input logic is_s2);
      if (is_s2) return (m == MODE_BOTH) || (m == MODE_S2);
      else       return (m != MODE_S2);
   endfunction
endpackage

// File: rtl/wfr_step_classify.sv
module wfr_step_classify
   import wfr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        valid,
   input  xlate_mode_e mode,
   input  logic        is_s2,
   input  logic        is_last,
   input  logic        chk_fail,
   input  logic        v,
   input  logic        r,
   input  logic        w,
   input  logic        x,
   input  logic        sel_hi_nz,
   output fault_e      prim,
   output logic        ppn_af
);
   logic active;
   logic bad_pte;

   assign active  = valid && stage_active(mode, is_s2);
   assign bad_pte = !v || (w && !r) || (is_last && !r && !w && !x);

   always_comb begin
      prim   = FLT_NONE;
      ppn_af = 1'b0;
      if (active) begin
         if (chk_fail) begin
            prim = FLT_AF;
         end else begin
            if (bad_pte) prim = is_s2 ? FLT_GPF : FLT_PF;
            ppn_af = sel_hi_nz;
         end
      end
   end

   // R6
   no_gpf_s1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_S1 || mode == MODE_BARE) |-> prim != FLT_GPF);
   // R6
   no_pf_s2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_S2) |-> prim != FLT_PF);
   // R3
   chk_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && chk_fail && stage_active(mode, is_s2)) |-> (prim == FLT_AF && !ppn_af));
endmodule

// File: rtl/wfr_refill_gate.sv
module wfr_refill_gate
   import wfr_pkg::*;
#(
   parameter int GROUP = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic             chk_fail,
   input  xlate_mode_e      mode,
   input  logic [GROUP-1:0] hi_nz,
   input  logic [SEL_W-1:0] sel,
   output logic             sel_hi_nz,
   output logic             refill_ok
);
   logic [GROUP-1:0] blocker;
   logic             own_only;

   assign own_only = (mode == MODE_S2);

   for (genvar gi = 0; gi < GROUP; gi++) begin : g_entry
      assign blocker[gi] = hi_nz[gi] && (!own_only || (sel == SEL_W'(gi)));
   end

   assign sel_hi_nz = hi_nz[sel];
   assign refill_ok = valid && !chk_fail && (blocker == '0);

   // R8
   group_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_only && (hi_nz != '0)) |-> !refill_ok);
endmodule

// File: rtl/wfr_fault_track.sv
module wfr_fault_track
   import wfr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   flush,
   input  logic   step_valid,
   input  fault_e step_prim,
   input  logic   step_ppn,
   input  logic   walk_end,
   output logic   done,
   output fault_e code,
   output logic   halt
);
   fault_e prim_q, prim_d, base_prim, end_code;
   logic   ppn_q, ppn_d, base_ppn, clr;

   assign clr = start || flush;

   always_comb begin
      base_prim = clr ? FLT_NONE : prim_q;
      base_ppn  = clr ? 1'b0 : ppn_q;
      prim_d    = base_prim;
      ppn_d     = base_ppn;
      if (step_valid && !flush) begin
         if (base_prim == FLT_NONE) prim_d = step_prim;
         ppn_d = base_ppn || step_ppn;
      end
      if (prim_d != FLT_NONE) end_code = prim_d;
      else if (ppn_d)         end_code = FLT_AF;
      else                    end_code = FLT_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prim_q <= FLT_NONE;
         ppn_q  <= 1'b0;
         done   <= 1'b0;
         code   <= FLT_NONE;
      end else begin
         prim_q <= prim_d;
         ppn_q  <= ppn_d;
         done   <= walk_end && !flush;
         code   <= (walk_end && !flush) ? end_code : FLT_NONE;
      end
   end

   assign halt = (prim_q != FLT_NONE);

   // R5
   sticky_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prim_q != FLT_NONE && !start && !flush) |=> prim_q == $past(prim_q));
   // R2
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(walk_end));
   // R9
   flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !done && !halt);
endmodule

// File: rtl/walk_fault_resolver.sv
module walk_fault_resolver
   import wfr_pkg::*;
#(
   parameter int GROUP = 8,
   parameter int SEL_W = (GROUP > 1) ? $clog2(GROUP) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             flush_i,
   input  logic [1:0]       mode_i,
   input  logic             step_valid_i,
   input  logic             step_stage2_i,
   input  logic             step_last_i,
   input  logic             chk_fail_i,
   input  logic             pte_v_i,
   input  logic             pte_r_i,
   input  logic             pte_w_i,
   input  logic             pte_x_i,
   input  logic [GROUP-1:0] grp_hi_nz_i,
   input  logic [SEL_W-1:0] grp_sel_i,
   input  logic             walk_end_i,
   output logic             done_o,
   output logic             fault_valid_o,
   output logic [1:0]       fault_code_o,
   output logic             halt_o,
   output logic             refill_ok_o
);
   localparam int SEL_MIN = (GROUP > 1) ? $clog2(GROUP) : 1;

   initial begin
      group_size_chk: assert (GROUP >= 2 && (GROUP & (GROUP - 1)) == 0)
         else $error("GROUP must be a power of two, at least 2");
      sel_width_chk: assert (SEL_W >= SEL_MIN)
         else $error("SEL_W too narrow for GROUP");
   end

   xlate_mode_e mode;
   fault_e      step_prim, res_code;
   logic        step_ppn, sel_hi;

   assign mode = xlate_mode_e'(mode_i);

   wfr_refill_gate #(.GROUP(GROUP), .SEL_W(SEL_W)) i_gate (
      .clk(clk), .rst_n(rst_n), .valid(step_valid_i), .chk_fail(chk_fail_i),
      .mode(mode), .hi_nz(grp_hi_nz_i), .sel(grp_sel_i),
      .sel_hi_nz(sel_hi), .refill_ok(refill_ok_o));

   wfr_step_classify i_cls (
      .clk(clk), .rst_n(rst_n), .valid(step_valid_i), .mode(mode),
      .is_s2(step_stage2_i), .is_last(step_last_i), .chk_fail(chk_fail_i),
      .v(pte_v_i), .r(pte_r_i), .w(pte_w_i), .x(pte_x_i),
      .sel_hi_nz(sel_hi), .prim(step_prim), .ppn_af(step_ppn));

   wfr_fault_track i_trk (
      .clk(clk), .rst_n(rst_n), .start(start_i), .flush(flush_i),
      .step_valid(step_valid_i), .step_prim(step_prim), .step_ppn(step_ppn),
      .walk_end(walk_end_i), .done(done_o), .code(res_code), .halt(halt_o));

   assign fault_code_o  = res_code;
   assign fault_valid_o = done_o && (res_code != FLT_NONE);
endmodule

// File: tb/test_walk_fault_resolver.sv
`timescale 1ns/100ps
module test_walk_fault_resolver;
   localparam int GROUP = 8;
   localparam int SEL_W = 3;

   logic clk = 0, rst_n = 0;
   logic start_i = 0, flush_i = 0, step_valid_i = 0, step_stage2_i = 0, step_last_i = 0;
   logic chk_fail_i = 0, pte_v_i = 0, pte_r_i = 0, pte_w_i = 0, pte_x_i = 0, walk_end_i = 0;
   logic [1:0] mode_i = 0;
   logic [GROUP-1:0] grp_hi_nz_i = 0;
   logic [SEL_W-1:0] grp_sel_i = 0;
   logic done_o, fault_valid_o, halt_o, refill_ok_o;
   logic [1:0] fault_code_o;

   int checks = 0, fails = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   walk_fault_resolver #(.GROUP(GROUP), .SEL_W(SEL_W)) i_walk_fault_resolver (.*);

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      {start_i, flush_i, step_valid_i, walk_end_i, chk_fail_i} = '0;
      grp_hi_nz_i = '0;
      @(posedge clk); #1;
   endtask

   task automatic begin_walk(input logic [1:0] m);
      @(negedge clk);
      {flush_i, step_valid_i, walk_end_i, chk_fail_i} = '0;
      mode_i = m; start_i = 1;
      @(posedge clk); #1;
   endtask

   // pte = {v,r,w,x}
   task automatic step(input logic s2, input logic last, input logic chk, input logic [3:0] pte,
                       input logic [GROUP-1:0] hi, input logic [SEL_W-1:0] sel, input logic fin);
      @(negedge clk);
      start_i = 0; flush_i = 0; step_valid_i = 1;
      step_stage2_i = s2; step_last_i = last; chk_fail_i = chk;
      {pte_v_i, pte_r_i, pte_w_i, pte_x_i} = pte;
      grp_hi_nz_i = hi; grp_sel_i = sel; walk_end_i = fin;
      @(posedge clk); #1;
   endtask

   task automatic expect_end(input string req, input logic [1:0] code);
      check({req, " done"}, {3'b0, done_o}, 4'h1);
      check({req, " code"}, {2'b0, fault_code_o}, {2'b0, code});
      check({req, " fvalid"}, {3'b0, fault_valid_o}, {3'b0, code != 2'b00});
   endtask

   localparam logic [3:0] NONLEAF = 4'b1000, LEAF = 4'b1100, BAD = 4'b0000;

   task automatic t_reset();
      check("R2 reset outputs", {done_o, fault_valid_o, fault_code_o}, 4'h0);
      check("R5 reset halt", {3'b0, halt_o}, 4'h0);
   endtask

   task automatic t_clean();
      begin_walk(2'b00);
      step(1, 0, 0, NONLEAF, 0, 0, 0);
      step(0, 1, 0, LEAF, 0, 0, 1);
      expect_end("R2 clean walk", 2'b00);
      idle();
      check("R2 done one cycle", {3'b0, done_o}, 4'h0);
   endtask

   task automatic t_first_wins();
      begin_walk(2'b00);
      step(0, 0, 0, BAD, 0, 0, 0);
      check("R5 halt after pf", {3'b0, halt_o}, 4'h1);
      step(1, 1, 0, BAD, 0, 0, 1);
      expect_end("R5 pf before gpf", 2'b01);
      begin_walk(2'b00);
      check("R9 start clears halt", {3'b0, halt_o}, 4'h0);
      step(1, 0, 0, BAD, 0, 0, 0);
      step(0, 1, 1, BAD, 0, 0, 1);
      expect_end("R5 earlier gpf kept", 2'b10);
   endtask

   task automatic t_chk();
      begin_walk(2'b00);
      step(0, 0, 1, BAD, 8'h01, 0, 1);
      expect_end("R3 check failure af", 2'b11);
   endtask

   task automatic t_ppn();
      begin_walk(2'b00);
      step(0, 0, 0, NONLEAF, 8'h04, 2, 0);
      check("R7 deferred no halt", {3'b0, halt_o}, 4'h0);
      step(0, 1, 0, LEAF, 0, 0, 1);
      expect_end("R7 ppn af alone", 2'b11);
      begin_walk(2'b00);
      step(0, 0, 0, NONLEAF, 8'h04, 2, 0);
      step(0, 1, 0, BAD, 0, 0, 1);
      expect_end("R7 pf beats ppn af", 2'b01);
      begin_walk(2'b00);
      step(0, 1, 0, LEAF, 8'h04, 3, 1);
      expect_end("R7 unselected entry", 2'b00);
   endtask

   task automatic t_leaf();
      begin_walk(2'b00);
      step(0, 0, 0, NONLEAF, 0, 0, 0);
      step(0, 1, 0, NONLEAF, 0, 0, 1);
      expect_end("R4 last nonleaf pf", 2'b01);
      begin_walk(2'b00);
      step(0, 1, 0, 4'b1010, 0, 0, 1);
      expect_end("R4 w without r", 2'b01);
   endtask

   task automatic t_modes();
      begin_walk(2'b01);
      step(1, 0, 0, BAD, 0, 0, 0);
      step(0, 1, 0, LEAF, 0, 0, 1);
      expect_end("R6 R1 s1 only no gpf", 2'b00);
      begin_walk(2'b01);
      step(0, 1, 0, BAD, 0, 0, 1);
      expect_end("R6 s1 only pf", 2'b01);
      begin_walk(2'b11);
      step(1, 1, 0, BAD, 0, 0, 1);
      expect_end("R6 bare no gpf", 2'b00);
      begin_walk(2'b10);
      step(0, 0, 0, BAD, 0, 0, 0);
      step(1, 1, 0, BAD, 0, 0, 1);
      expect_end("R6 s2 only gpf", 2'b10);
      begin_walk(2'b10);
      step(1, 1, 1, LEAF, 0, 0, 1);
      expect_end("R3 s2 only af", 2'b11);
   endtask

   task automatic t_refill();
      begin_walk(2'b00);
      step(0, 0, 0, NONLEAF, 8'h20, 0, 0);
      check("R8 group blocked", {3'b0, refill_ok_o}, 4'h0);
      step(0, 0, 0, NONLEAF, 8'h00, 0, 0);
      check("R8 group clean", {3'b0, refill_ok_o}, 4'h1);
      step(0, 0, 1, NONLEAF, 8'h00, 0, 0);
      check("R8 check failure no refill", {3'b0, refill_ok_o}, 4'h0);
      idle();
      check("R8 no step no refill", {3'b0, refill_ok_o}, 4'h0);
      begin_walk(2'b10);
      step(1, 0, 0, NONLEAF, 8'h20, 0, 0);
      check("R8 s2 other entry", {3'b0, refill_ok_o}, 4'h1);
      step(1, 0, 0, NONLEAF, 8'h20, 5, 0);
      check("R8 s2 own entry", {3'b0, refill_ok_o}, 4'h0);
   endtask

   task automatic t_flush();
      begin_walk(2'b00);
      step(0, 0, 0, NONLEAF, 8'h01, 0, 0);
      @(negedge clk); step_valid_i = 0; flush_i = 1; @(posedge clk); #1;
      step(0, 1, 0, LEAF, 0, 0, 1);
      expect_end("R9 flush clears ppn", 2'b00);
      begin_walk(2'b00);
      step(0, 0, 0, BAD, 0, 0, 0);
      @(negedge clk); step_valid_i = 0; flush_i = 1; walk_end_i = 1; @(posedge clk); #1;
      check("R9 flush suppresses done", {2'b0, done_o, halt_o}, 4'h0);
      begin_walk(2'b00);
      step(0, 0, 0, NONLEAF, 8'h01, 0, 0);
      begin_walk(2'b00);
      step(0, 1, 0, LEAF, 0, 0, 1);
      expect_end("R9 start clears ppn", 2'b00);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_clean();
      t_first_wins();
      t_chk();
      t_ppn();
      t_leaf();
      t_modes();
      t_refill();
      t_flush();
      idle();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule